// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Direction Counters

This block predicts the next fetch address for the instruction fetch stage. It is a direct-mapped table. The low bits of the word-aligned fetch PC pick an entry, and the remaining upper bits are held as a tag. Each entry holds a valid flag, a tag, a stored branch target and a two-bit saturating direction counter. When the entry matches and its counter leans taken, the fetch unit is handed the stored target. Otherwise it is handed PC+4. A prediction is presented one clock after the fetch PC is offered.

Branches resolve later in the pipeline and report back through an update port. A resolved taken branch that misses in the table claims its entry and starts in the weakly-taken state. A resolved branch that hits moves its counter one step towards the outcome, and a taken outcome also refreshes the stored target. The counter has two states on each side, so a single contrary outcome, such as the exit from a loop, does not reverse a firmly established prediction. The pipeline carries the fetch-time prediction alongside the branch and hands it back with the resolution. The block then raises a one-cycle mispredict flag, which the surrounding pipeline uses to flush. The PC register, the instruction memory and the flush itself are outside this block.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous reset clears every valid flag, so every lookup after reset misses until an update writes the entry. During reset `pred_valid` and `mispredict` read 0.
- R2: `pred_valid` follows `fetch_valid` one clock later. `pred_hit`, `pred_taken` and `pred_next_pc` describe the PC that was offered in that earlier cycle. `pred_hit` and `pred_taken` are 0 whenever `pred_valid` is 0.
- R3: The entry index is PC[IDX_W+1:2]. The tag is PC[ADDR_W-1:IDX_W+2]. PC bits [1:0] take no part in either. A lookup hits when the indexed entry is valid and its tag equals the PC tag.
- R4: `pred_taken` is 1 when the lookup hits and the counter is 2 or 3. In that case `pred_next_pc` is the stored target. In every other case `pred_next_pc` is the fetch PC plus 4.
- R5: A taken update that misses writes the tag and the target into the indexed entry, evicting any other tag held there, and sets the counter to 2 (weakly taken).
- R6: An update that hits increments the counter on taken, saturating at 3, and decrements it on not-taken, saturating at 0. A taken update that hits also replaces the stored target.
- R7: An entry at counter 3 still predicts taken after one not-taken update. It predicts not-taken only after a second one.
- R8: `mispredict` is 1 in the cycle after an update exactly when the resolved direction differs from the fetch-time direction, or when both are taken and the resolved target differs from the fetch-time target. Without an update it is 0.
- R9: When a lookup and an update address the same entry in one cycle, the lookup reports the entry as it stood before that update.
- R10: A not-taken update that misses changes nothing. An entry held there under another tag keeps predicting as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetch PC is offered this cycle |
| fetch_pc | input | ADDR_W | Fetch-stage PC |
| pred_valid | output | 1 | Prediction for the previous cycle's fetch is present |
| pred_hit | output | 1 | That fetch matched a valid entry |
| pred_taken | output | 1 | That fetch is predicted taken |
| pred_next_pc | output | ADDR_W | Predicted next fetch address |
| upd_valid | input | 1 | A branch resolution is reported |
| upd_pc | input | ADDR_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | ADDR_W | Resolved target address |
| upd_pred_taken | input | 1 | Direction predicted for this branch at fetch |
| upd_pred_target | input | ADDR_W | Next PC predicted for this branch at fetch |
| mispredict | output | 1 | Registered flag: the prediction was wrong |

## Verification
A lookup and an update can land on the same entry in the same clock. That is where a wrong read-during-write order would show, since the lookup must see the entry before the update. The bench provokes this with a directed cycle that fetches and resolves one branch together, and again through random traffic confined to a few tags and indices so that such collisions recur often. The bench keeps a reference table of its own. It computes each expected prediction from that table before applying the same-cycle update to it, then compares the registered outputs one clock later.

// File: rtl/btb_pkg.sv
package btb_pkg;

  localparam logic [1:0] CTR_WEAK_TAKEN = 2'd2;

  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    nxt = cur;
    if (taken) begin
      if (cur != 2'd3) nxt = cur + 2'd1;
    end else begin
      if (cur != 2'd0) nxt = cur - 2'd1;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/btb_tag_store.sv
module btb_tag_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] la_idx,
  output logic             la_valid,
  output logic [TAG_W-1:0] la_tag,
  output logic [1:0]       la_ctr,
  input  logic [IDX_W-1:0] lb_idx,
  output logic             lb_valid,
  output logic [TAG_W-1:0] lb_tag,
  output logic [1:0]       lb_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [1:0]       wr_ctr
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] valid_q;
  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [1:0]       ctr_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      ctr_mem[wr_idx] <= wr_ctr;
    end
  end

  assign la_valid = valid_q[la_idx];
  assign la_tag   = tag_mem[la_idx];
  assign la_ctr   = ctr_mem[la_idx];
  assign lb_valid = valid_q[lb_idx];
  assign lb_tag   = tag_mem[lb_idx];
  assign lb_ctr   = ctr_mem[lb_idx];
endmodule

// File: rtl/btb_target_ram.sv
module btb_target_ram #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_idx];
    if (wr_en) mem[wr_idx] <= wr_data;
  end
endmodule

// File: rtl/btb_update_ctrl.sv
module btb_update_ctrl
  import btb_pkg::*;
(
  input  logic       upd_valid,
  input  logic       upd_taken,
  input  logic       entry_hit,
  input  logic [1:0] entry_ctr,
  output logic       meta_we,
  output logic       tgt_we,
  output logic [1:0] new_ctr
);
  always_comb begin
    meta_we = 1'b0;
    tgt_we  = 1'b0;
    new_ctr = entry_ctr;
    if (upd_valid) begin
      if (entry_hit) begin
        meta_we = 1'b1;
        tgt_we  = upd_taken;
        new_ctr = ctr_step(entry_ctr, upd_taken);
      end else if (upd_taken) begin
        meta_we = 1'b1;
        tgt_we  = 1'b1;
        new_ctr = CTR_WEAK_TAKEN;
      end
    end
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_valid,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_next_pc,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              upd_pred_taken,
  input  logic [ADDR_W-1:0] upd_pred_target,
  output logic              mispredict
);
  localparam int TAG_W  = ADDR_W - 2 - IDX_W;
  localparam int IDX_LO = 2;
  localparam int TAG_LO = IDX_W + 2;

  logic [IDX_W-1:0] f_idx, u_idx;
  logic [TAG_W-1:0] f_tag, u_tag;
  assign f_idx = fetch_pc[TAG_LO-1:IDX_LO];
  assign f_tag = fetch_pc[ADDR_W-1:TAG_LO];
  assign u_idx = upd_pc[TAG_LO-1:IDX_LO];
  assign u_tag = upd_pc[ADDR_W-1:TAG_LO];

  logic             fv_ent, uv_ent;
  logic [TAG_W-1:0] f_ent_tag, u_ent_tag;
  logic [1:0]       f_ent_ctr, u_ent_ctr;
  logic             meta_we, tgt_we;
  logic [1:0]       new_ctr;
  logic [ADDR_W-1:0] tgt_rd;

  btb_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .la_idx   (f_idx),
    .la_valid (fv_ent),
    .la_tag   (f_ent_tag),
    .la_ctr   (f_ent_ctr),
    .lb_idx   (u_idx),
    .lb_valid (uv_ent),
    .lb_tag   (u_ent_tag),
    .lb_ctr   (u_ent_ctr),
    .wr_en    (meta_we),
    .wr_idx   (u_idx),
    .wr_tag   (u_tag),
    .wr_ctr   (new_ctr)
  );

  btb_target_ram #(.IDX_W(IDX_W), .DATA_W(ADDR_W)) u_tgt (
    .clk     (clk),
    .rd_idx  (f_idx),
    .rd_data (tgt_rd),
    .wr_en   (tgt_we),
    .wr_idx  (u_idx),
    .wr_data (upd_target)
  );

  logic u_hit;
  assign u_hit = uv_ent && (u_ent_tag == u_tag);

  btb_update_ctrl u_ctrl (
    .upd_valid (upd_valid),
    .upd_taken (upd_taken),
    .entry_hit (u_hit),
    .entry_ctr (u_ent_ctr),
    .meta_we   (meta_we),
    .tgt_we    (tgt_we),
    .new_ctr   (new_ctr)
  );

  logic f_hit, f_take;
  assign f_hit  = fetch_valid && fv_ent && (f_ent_tag == f_tag);
  assign f_take = f_hit && f_ent_ctr[1];

  logic [ADDR_W-1:0] seq_pc_q;
  logic              misp_d;

  assign misp_d = upd_valid &&
                  ((upd_taken != upd_pred_taken) ||
                   (upd_taken && (upd_target != upd_pred_target)));

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_hit   <= 1'b0;
      pred_taken <= 1'b0;
      mispredict <= 1'b0;
      seq_pc_q   <= '0;
    end else begin
      pred_valid <= fetch_valid;
      pred_hit   <= f_hit;
      pred_taken <= f_take;
      mispredict <= misp_d;
      seq_pc_q   <= fetch_pc + ADDR_W'(4);
    end
  end

  assign pred_next_pc = pred_taken ? tgt_rd : seq_pc_q;
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              pred_valid,
  input logic              pred_hit,
  input logic              pred_taken,
  input logic [ADDR_W-1:0] pred_next_pc,
  input logic              upd_valid,
  input logic [ADDR_W-1:0] upd_pc,
  input logic              upd_taken,
  input logic [ADDR_W-1:0] upd_target,
  input logic              upd_pred_taken,
  input logic [ADDR_W-1:0] upd_pred_target,
  input logic              mispredict
);
  AST_VALID_FOLLOWS_FETCH: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pred_valid == $past(fetch_valid)); // R2

  AST_NO_HIT_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pred_valid |-> !pred_hit && !pred_taken); // R2

  AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    pred_taken |-> pred_hit); // R4

  AST_SEQ_NEXT_PC: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && pred_valid && !pred_taken) |-> pred_next_pc == $past(fetch_pc) + ADDR_W'(4)); // R4

  AST_MISP_ON_DIR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(upd_valid) && ($past(upd_taken) != $past(upd_pred_taken))) |-> mispredict); // R8

  AST_MISP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(upd_valid)) |-> !mispredict); // R8

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> !pred_valid && !mispredict); // R1
endmodule

bind btb_predictor btb_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_btb_predictor.sv
`timescale 1ns/1ps
module tb_btb_predictor;
  localparam int AW = 32;
  localparam int IW = 4;
  localparam int TW = AW - 2 - IW;
  localparam int N  = 1 << IW;

  logic          clk = 1'b0;
  logic          rst;
  logic          fetch_valid;
  logic [AW-1:0] fetch_pc;
  logic          pred_valid, pred_hit, pred_taken;
  logic [AW-1:0] pred_next_pc;
  logic          upd_valid, upd_taken, upd_pred_taken;
  logic [AW-1:0] upd_pc, upd_target, upd_pred_target;
  logic          mispredict;

  always #2 clk = ~clk;

  btb_predictor #(.ADDR_W(AW), .IDX_W(IW)) dut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_taken(pred_taken),
    .pred_next_pc(pred_next_pc), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_target(upd_target),
    .upd_pred_taken(upd_pred_taken), .upd_pred_target(upd_pred_target),
    .mispredict(mispredict)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic          m_val [N];
  logic [TW-1:0] m_tag [N];
  logic [AW-1:0] m_tgt [N];
  logic [1:0]    m_ctr [N];

  function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
    if (t) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic chk(input string req, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req, input logic fv, input logic [AW-1:0] fpc,
                      input logic uv, input logic [AW-1:0] upc, input logic ut,
                      input logic [AW-1:0] utg, input logic upt, input logic [AW-1:0] uptg);
    logic e_hit, e_tk, e_mp;
    logic [AW-1:0] e_npc;
    int fi, ui;
    fetch_valid = fv; fetch_pc = fpc;
    upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg;
    upd_pred_taken = upt; upd_pred_target = uptg;
    fi = int'(fpc[IW+1:2]);
    ui = int'(upc[IW+1:2]);
    e_hit = fv && m_val[fi] && (m_tag[fi] == fpc[AW-1:IW+2]);
    e_tk  = e_hit && m_ctr[fi][1];
    e_npc = e_tk ? m_tgt[fi] : fpc + 32'd4;
    e_mp  = uv && ((ut != upt) || (ut && utg != uptg));
    if (uv) begin
      if (m_val[ui] && m_tag[ui] == upc[AW-1:IW+2]) begin
        m_ctr[ui] = sat(m_ctr[ui], ut);
        if (ut) m_tgt[ui] = utg;
      end else if (ut) begin
        m_val[ui] = 1'b1; m_tag[ui] = upc[AW-1:IW+2];
        m_tgt[ui] = utg; m_ctr[ui] = 2'd2;
      end
    end
    @(negedge clk);
    chk(req, "pred_valid", AW'(pred_valid), AW'(fv));
    chk(req, "pred_hit", AW'(pred_hit), AW'(e_hit));
    chk(req, "pred_taken", AW'(pred_taken), AW'(e_tk));
    if (fv) chk(req, "pred_next_pc", pred_next_pc, e_npc);
    chk("R8", "mispredict", AW'(mispredict), AW'(e_mp));
  endtask

  task automatic fetch(input string req, input logic [AW-1:0] pc);
    step(req, 1'b1, pc, 1'b0, '0, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic upd(input string req, input logic [AW-1:0] pc, input logic t,
                     input logic [AW-1:0] tg, input logic pt, input logic [AW-1:0] ptg);
    step(req, 1'b0, '0, 1'b1, pc, t, tg, pt, ptg);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    fetch_valid = 1'b0; fetch_pc = '0; upd_valid = 1'b0; upd_pc = '0;
    upd_taken = 1'b0; upd_target = '0; upd_pred_taken = 1'b0; upd_pred_target = '0;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "pred_valid in reset", AW'(pred_valid), '0);
    chk("R1", "mispredict in reset", AW'(mispredict), '0);
    for (int i = 0; i < N; i++) m_val[i] = 1'b0;
    rst = 1'b0;
  endtask

  localparam logic [AW-1:0] PA = 32'h0000_1044;
  localparam logic [AW-1:0] PB = 32'h0000_2044;
  localparam logic [AW-1:0] T1 = 32'h0000_8000;
  localparam logic [AW-1:0] T2 = 32'h0000_9100;
  localparam logic [AW-1:0] T3 = 32'h0000_A200;

  initial begin
    for (int i = 0; i < N; i++) begin
      m_val[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = '0;
    end
    void'($urandom(32'd20240611));
    do_reset();
    fetch("R1", PA);
    upd("R5", PA, 1'b1, T1, 1'b0, PA + 32'd4);
    fetch("R4", PA);
    fetch("R3", PA | 32'h3);
    upd("R6", PA, 1'b1, T1, 1'b1, T1);
    upd("R7", PA, 1'b0, '0, 1'b1, T1);
    fetch("R7", PA);
    upd("R7", PA, 1'b0, '0, 1'b1, T1);
    fetch("R7", PA);
    upd("R6", PA, 1'b0, '0, 1'b0, PA + 32'd4);
    upd("R6", PA, 1'b0, '0, 1'b0, PA + 32'd4);
    upd("R6", PA, 1'b1, T1, 1'b0, PA + 32'd4);
    fetch("R6", PA);
    upd("R6", PA, 1'b1, T1, 1'b0, PA + 32'd4);
    fetch("R6", PA);
    upd("R10", PB, 1'b0, '0, 1'b0, PB + 32'd4);
    fetch("R10", PA);
    fetch("R10", PB);
    upd("R5", PB, 1'b1, T2, 1'b0, PB + 32'd4);
    fetch("R5", PA);
    step("R9", 1'b1, PB, 1'b1, PB, 1'b0, '0, 1'b1, T2);
    fetch("R9", PB);
    upd("R6", PB, 1'b1, T3, 1'b0, PB + 32'd4);
    fetch("R6", PB);
    upd("R8", PB, 1'b1, T3, 1'b1, T2);
    for (int k = 0; k < 4000; k++) begin
      logic [AW-1:0] fp, up;
      fp = {22'h0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), 2'b00} + 32'h0000_4000;
      up = {22'h0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), 2'b00} + 32'h0000_4000;
      if ($urandom_range(0, 3) == 0) up = fp;
      step("R4", 1'($urandom_range(0, 1)), fp, 1'($urandom_range(0, 1)), up,
           1'($urandom_range(0, 1)), {$urandom_range(0, 255), 2'b00},
           1'($urandom_range(0, 1)), {$urandom_range(0, 255), 2'b00});
    end
    do_reset();
    fetch("R1", PB);
    fetch("R1", PA);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule